// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Reset Output

This block is a watchdog timer for a power-management device, reached through a simple 16-bit register port. Its configuration registers are guarded by a lock. Only after a fixed 16-bit key has been written to the lock register can software change the 32-bit timeout value or the control bits. Writing any other value to the lock register closes the lock again. The timeout value is spread over two 16-bit registers, one holding the lower half and one holding the upper half.

Once started, a 32-bit down-counter steps once per pulse of a slow tick strobe. That strobe is one clock wide and typically comes from a 32.768 kHz source. The counter runs only while two external gate inputs are both high. One gate enables the register interface and the other enables the counting clock. When the count runs out, the counter reloads from the timeout value. If the reset-enable control bit is set, the block also drives a system reset output high for a fixed number of clock cycles.

Top module: `pmic_wdog`

## Requirements
- R1: After synchronous reset, the block is locked, the timeout, control and count registers read zero, and `sys_rst` is low.
- R2: A write of the key (default 16'hE551) to the lock register (offset 8'hA0) unlocks configuration writes; the lock register then reads 16'h0000.
- R3: A write of any other value to the lock register (for example 16'h1AAE) locks the block; the lock register then reads 16'h0001 (bit 0 = locked).
- R4: While locked, writes to the timeout-low (8'h80), timeout-high (8'h84) and control (8'h88) registers leave their read-back contents unchanged.
- R5: The 32-bit timeout is {high register, low register}. The live count reads back as its low half at 8'h90 and its high half at 8'h94.
- R6: When the run bit (control bit 1) changes from 0 to 1, the counter loads the full 32-bit timeout value in that cycle; any tick in that cycle is not counted.
- R7: The counter decrements by one on each clock cycle with `tick` high, but only while run is set and both `bus_en` and `cnt_en` are high; otherwise it holds.
- R8: A tick that takes the count from 1 to 0 is an expiry. On an expiry with reset enabled (control bit 3), `sys_rst` goes high from the next clock edge for exactly PULSE_CYC cycles, and the counter reloads the timeout value.
- R9: An expiry with control bit 3 clear reloads the counter and leaves `sys_rst` low.
- R10: A timeout value of zero expires on the first counted tick after start.
- R11: While `bus_en` is low, register writes have no effect, including writes to the lock register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register interface enable gate |
| cnt_en | input | 1 | Counting clock enable gate |
| tick | input | 1 | One-cycle slow count strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
The bench builds the block with PULSE_CYC set to 4. This makes the whole reset pulse, including its first and last cycle, easy to count in a short window. It keeps the default key and uses timeout values of 0, 1 and 2 plus one value with a non-zero upper half. With these values, expiry, reload, zero-timeout expiry and the assembly of the split timeout are all reached within a handful of ticks, not the real timeout length.

// File: rtl/pwdg_pkg.sv
package pwdg_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 2 * REG_W;

    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h88;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 8'hA0;

    localparam int CTRL_RUN_BIT = 1;
    localparam int CTRL_RST_BIT = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOAD_LO,
        SEL_LOAD_HI,
        SEL_CTRL,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_LOCK
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic rst_en;
    } ctrl_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_LOAD_LO: s = SEL_LOAD_LO;
            OFS_LOAD_HI: s = SEL_LOAD_HI;
            OFS_CTRL:    s = SEL_CTRL;
            OFS_CNT_LO:  s = SEL_CNT_LO;
            OFS_CNT_HI:  s = SEL_CNT_HI;
            OFS_LOCK:    s = SEL_LOCK;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[CTRL_RUN_BIT] = c.run;
        v[CTRL_RST_BIT] = c.rst_en;
        return v;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] v);
        ctrl_t c;
        c.run    = v[CTRL_RUN_BIT];
        c.rst_en = v[CTRL_RST_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pwdg_regs.sv
module pwdg_regs
    import pwdg_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [REG_W-1:0]  rdata,
    output logic [CNT_W-1:0]  load,
    output ctrl_t             ctrl,
    output logic              locked
);

    logic [REG_W-1:0] load_lo;
    logic [REG_W-1:0] load_hi;
    reg_sel_e         sel;
    logic             wr_ok;

    assign sel   = decode_ofs(addr);
    assign wr_ok = wr_en && bus_en;
    assign load  = {load_hi, load_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            locked  <= 1'b1;
            load_lo <= '0;
            load_hi <= '0;
            ctrl    <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_LOCK:    locked <= (wdata != KEY);
                SEL_LOAD_LO: if (!locked) load_lo <= wdata;
                SEL_LOAD_HI: if (!locked) load_hi <= wdata;
                SEL_CTRL:    if (!locked) ctrl <= ctrl_unpack(wdata);
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_LOAD_LO: rdata = load_lo;
            SEL_LOAD_HI: rdata = load_hi;
            SEL_CTRL:    rdata = ctrl_pack(ctrl);
            SEL_CNT_LO:  rdata = count[REG_W-1:0];
            SEL_CNT_HI:  rdata = count[CNT_W-1:REG_W];
            SEL_LOCK:    rdata = {{(REG_W-1){1'b0}}, locked};
            default:     rdata = '0;
        endcase
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_en && addr == OFS_LOCK && wdata == KEY) |=> !locked); // R2

    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_en && addr == OFS_LOCK && wdata != KEY) |=> locked); // R3

    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && !(wr_en && bus_en && addr == OFS_LOCK)) |=> ($stable(load) && $stable(ctrl))); // R4

    AST_GATED_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> ($stable(locked) && $stable(load) && $stable(ctrl))); // R11

endmodule

// File: rtl/pwdg_counter.sv
module pwdg_counter
    import pwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             gates_on,
    input  logic             tick,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic run_prev;
    logic run_rise;
    logic step;
    logic at_end;

    assign run_rise = run && !run_prev;
    assign step     = run && gates_on && tick && !run_rise;
    assign at_end   = (count <= CNT_W'(1));
    assign expire   = step && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_prev <= 1'b0;
            count    <= '0;
        end else begin
            run_prev <= run;
            if (run_rise) begin
                count <= load;
            end else if (step) begin
                if (at_end) count <= load;
                else        count <= count - CNT_W'(1);
            end
        end
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        run_rise |=> (count == $past(load))); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_rise && !(run && gates_on && tick)) |=> $stable(count)); // R7

    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == $past(load))); // R8

    AST_NO_EXPIRE_GATED: assert property (@(posedge clk) disable iff (rst)
        !gates_on |-> !expire); // R7

endmodule

// File: rtl/pwdg_rst_pulse.sv
module pwdg_rst_pulse #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic rst_en,
    output logic pulse
);

    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (expire && rst_en) begin
            remain <= PW'(PULSE_CYC);
        end else if (remain != '0) begin
            remain <= remain - PW'(1);
        end
    end

    assign pulse = (remain != '0);

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(expire && rst_en)); // R8

    AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !(expire && rst_en)) |=> !pulse); // R9

endmodule

// File: rtl/pmic_wdog.sv
module pmic_wdog
    import pwdg_pkg::*;
#(
    parameter int               PULSE_CYC = 8,
    parameter logic [REG_W-1:0] KEY       = 16'hE551
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              cnt_en,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              sys_rst
);

    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    logic             locked;
    logic             expire;
    logic             gates_on;

    assign gates_on = bus_en && cnt_en;

    pwdg_regs #(.KEY(KEY)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .bus_en (bus_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .count  (count),
        .rdata  (rdata),
        .load   (load),
        .ctrl   (ctrl),
        .locked (locked)
    );

    pwdg_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .gates_on (gates_on),
        .tick     (tick),
        .load     (load),
        .count    (count),
        .expire   (expire)
    );

    pwdg_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .rst_en (ctrl.rst_en),
        .pulse  (sys_rst)
    );

    AST_RST_LOW_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !sys_rst); // R1

endmodule

// File: tb/test_pmic_wdog.sv
module test_pmic_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam logic [15:0] KEY = 16'hE551;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b1;
    logic        cnt_en = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        sys_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmic_wdog #(.PULSE_CYC(PULSE), .KEY(KEY)) i_pmic_wdog (
        .clk(clk), .rst(rst), .bus_en(bus_en), .cnt_en(cnt_en), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst(sys_rst)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd32(output logic [31:0] v);
        logic [15:0] lo, hi;
        rd(8'h90, lo);
        rd(8'h94, hi);
        v = {hi, lo};
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Counts sys_rst high cycles, starting right after the expiring tick's edge.
    task automatic pulse_len(output int n);
        n = sys_rst ? 1 : 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sys_rst) n++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(8'h80, v); chk(v == 16'h0, "R1 load_lo", v, 0);
        rd(8'h84, v); chk(v == 16'h0, "R1 load_hi", v, 0);
        rd(8'h88, v); chk(v == 16'h0, "R1 ctrl", v, 0);
        rd(8'h90, v); chk(v == 16'h0, "R1 count", v, 0);
        rd(8'hA0, v); chk(v == 16'h1, "R1 locked", v, 1);
        chk(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);
    endtask

    task automatic t_locked_writes();
        logic [15:0] v;
        wr(8'h80, 16'h1234);
        wr(8'h84, 16'h5678);
        wr(8'h88, 16'h000A);
        rd(8'h80, v); chk(v == 16'h0, "R4 locked load_lo", v, 0);
        rd(8'h84, v); chk(v == 16'h0, "R4 locked load_hi", v, 0);
        rd(8'h88, v); chk(v == 16'h0, "R4 locked ctrl", v, 0);
    endtask

    task automatic t_bus_gate();
        logic [15:0] v;
        bus_en = 1'b0;
        wr(8'hA0, KEY);
        rd(8'hA0, v); chk(v == 16'h1, "R11 key ignored with bus gate off", v, 1);
        bus_en = 1'b1;
    endtask

    task automatic t_unlock_split();
        logic [15:0] v;
        logic [31:0] c;
        wr(8'hA0, KEY);
        rd(8'hA0, v); chk(v == 16'h0, "R2 unlocked", v, 0);
        wr(8'h80, 16'h0003);
        wr(8'h84, 16'h0001);
        rd(8'h80, v); chk(v == 16'h0003, "R5 load_lo", v, 3);
        rd(8'h84, v); chk(v == 16'h0001, "R5 load_hi", v, 1);
        bus_en = 1'b0;
        wr(8'h80, 16'h7777);
        bus_en = 1'b1;
        rd(8'h80, v); chk(v == 16'h0003, "R11 unlocked write gated", v, 3);
        wr(8'h88, 16'h0002);
        rd32(c); chk(c == 32'h0001_0003, "R6 R5 start loads 32-bit", c, 32'h0001_0003);
    endtask

    task automatic t_count();
        logic [31:0] c;
        cnt_en = 1'b0;
        do_tick();
        rd32(c); chk(c == 32'h0001_0003, "R7 hold with cnt_en low", c, 32'h0001_0003);
        cnt_en = 1'b1;
        do_tick();
        rd32(c); chk(c == 32'h0001_0002, "R7 decrement", c, 32'h0001_0002);
        do_tick();
        rd32(c); chk(c == 32'h0001_0001, "R7 decrement again", c, 32'h0001_0001);
        do_tick();
        rd32(c); chk(c == 32'h0001_0000, "R7 borrow step", c, 32'h0001_0000);
        do_tick();
        rd32(c); chk(c == 32'h0000_FFFF, "R7 borrow into high", c, 32'h0000_FFFF);
    endtask

    task automatic t_relock();
        logic [15:0] v;
        wr(8'hA0, ~KEY);
        rd(8'hA0, v); chk(v == 16'h1, "R3 relocked", v, 1);
        wr(8'h80, 16'h0055);
        rd(8'h80, v); chk(v == 16'h0003, "R3 R4 write after relock ignored", v, 3);
        wr(8'hA0, KEY);
    endtask

    task automatic t_expire_rst();
        logic [31:0] c;
        int n;
        wr(8'h88, 16'h0000);
        wr(8'h84, 16'h0000);
        wr(8'h80, 16'h0002);
        wr(8'h88, 16'h000A);
        rd32(c); chk(c == 32'd2, "R6 restart load", c, 2);
        do_tick();
        chk(sys_rst == 1'b0, "R8 no pulse before expiry", sys_rst, 0);
        do_tick();
        chk(sys_rst == 1'b1, "R8 pulse starts next edge", sys_rst, 1);
        pulse_len(n);
        chk(n == PULSE, "R8 pulse length", n, PULSE);
        rd32(c); chk(c == 32'd2, "R8 reload after expiry", c, 2);
    endtask

    task automatic t_expire_norst();
        logic [31:0] c;
        int n;
        wr(8'h88, 16'h0000);
        wr(8'h80, 16'h0001);
        wr(8'h88, 16'h0002);
        do_tick();
        pulse_len(n);
        chk(n == 0, "R9 no pulse without reset enable", n, 0);
        rd32(c); chk(c == 32'd1, "R9 reload", c, 1);
    endtask

    task automatic t_zero();
        int n;
        wr(8'h88, 16'h0000);
        wr(8'h80, 16'h0000);
        wr(8'h88, 16'h000A);
        do_tick();
        chk(sys_rst == 1'b1, "R10 zero timeout expires on first tick", sys_rst, 1);
        pulse_len(n);
        chk(n == PULSE, "R10 pulse length", n, PULSE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked_writes();
        t_bus_gate();
        t_unlock_split();
        t_count();
        t_relock();
        t_expire_rst();
        t_expire_norst();
        t_zero();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule